// File: doc/BRIEF.md
# Flash Block Protection State Controller

This block keeps the write-protection state of every erase block in a flash device model. Each block is in one of three states: open, locked, or pinned. Pinned is a stronger lock that no unlock command can undo; only a reset clears it. The state changes through a two-byte command. A setup byte arms the block. The next command write then picks the action and names the target block.

The same command write stream that feeds the main sequencer reaches this block as byte writes with a block index. The block acts only on its own setup byte and the byte that follows it. Any other write it ignores. When the main sequencer wants to program or erase a block, it asks this block first. The answer is a grant pulse, or a refusal pulse that drives status bit 1. An invalid byte after setup raises a sequence-error pulse that drives status bits 4 and 5. A query port returns the state of any block combinationally.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset every block reads as locked (code 01), no setup is armed, and `op_grant`, `sr_lock_err` and `sr_seq_err` are low. This also applies to blocks that were pinned before the reset.
- R2: `query_state` returns the addressed block's 2-bit code in the same cycle, with no clock edge between. The codes are 00 open, 01 locked and 11 pinned, and 10 never appears. An index at or above `BLOCKS` reads as 01.
- R3: A setup write (0x60) followed by a write of 0x01 makes the block named with the second write locked. A pinned block stays pinned.
- R4: A setup write followed by 0xD0 makes the named block open. If that block is pinned, nothing changes.
- R5: A setup write followed by 0x2F makes the named block pinned. A pinned block leaves that state only through reset.
- R6: A setup write followed by any byte other than 0x01, 0xD0, 0x2F or 0x03 raises `sr_seq_err` for exactly the one cycle after that write. No block state changes, and the setup is dropped. A second 0x60 counts as such a byte.
- R7: A setup write followed by 0x03 drops the setup. It raises no error and changes no block.
- R8: With no setup armed, any write other than 0x60 has no effect on any block and raises no error.
- R9: A request (`op_req`) for an open block gives a one-cycle `op_grant` in the next cycle. A request for a locked block, a pinned block, or an index at or above `BLOCKS` gives a one-cycle `sr_lock_err` in the next cycle. No request changes any block state.
- R10: A lock, unlock or pin command naming an index at or above `BLOCKS` changes no block and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_code | input | 8 | Command byte |
| cmd_blk | input | IDX_W | Block index that goes with the command byte |
| op_req | input | 1 | Program or erase permission request |
| op_blk | input | IDX_W | Block the request targets |
| query_blk | input | IDX_W | Block whose state is read |
| query_state | output | 2 | State code of `query_blk` |
| op_grant | output | 1 | Request granted, one-cycle pulse |
| sr_lock_err | output | 1 | Request refused, drives status bit 1 |
| sr_seq_err | output | 1 | Bad second byte, drives status bits 4 and 5 |

## Verification
Every action byte is sent against blocks in every state. This separates a block that is open from one that is locked or pinned, and shows that unlock and lock leave a pinned block pinned. Bad second bytes cover an arbitrary value, a repeated setup byte, and the configuration byte. These show the error pulse fires only where R6 calls for it, and that the setup is dropped after it. Second bytes sent with no setup armed, and indexes past the last block, must leave every state untouched. A reset taken while blocks are pinned or open must bring all of them back to locked.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

    typedef enum logic [1:0] {
        BLK_OPEN   = 2'b00,
        BLK_LOCKED = 2'b01,
        BLK_PINNED = 2'b11
    } blk_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_LOCK,
        ACT_UNLOCK,
        ACT_PIN
    } lock_act_e;

    localparam logic [7:0] CODE_SETUP  = 8'h60;
    localparam logic [7:0] CODE_LOCK   = 8'h01;
    localparam logic [7:0] CODE_UNLOCK = 8'hD0;
    localparam logic [7:0] CODE_PIN    = 8'h2F;
    localparam logic [7:0] CODE_CFG    = 8'h03;

    typedef struct packed {
        logic armed;
        logic seq_err;
    } cmd_reg_t;

    typedef struct packed {
        logic grant;
        logic deny;
    } gate_reg_t;

endpackage

// File: rtl/lock_cmd_fsm.sv
module lock_cmd_fsm
    import flash_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_code,
    output lock_act_e  act,
    output logic       seq_err
);

    cmd_reg_t cmd_d, cmd_q;

    always_comb begin
        cmd_d         = cmd_q;
        cmd_d.seq_err = 1'b0;
        act           = ACT_NONE;
        if (cmd_wr) begin
            if (cmd_q.armed) begin
                cmd_d.armed = 1'b0;
                case (cmd_code)
                    CODE_LOCK:   act = ACT_LOCK;
                    CODE_UNLOCK: act = ACT_UNLOCK;
                    CODE_PIN:    act = ACT_PIN;
                    CODE_CFG:    act = ACT_NONE;
                    default:     cmd_d.seq_err = 1'b1;
                endcase
            end else if (cmd_code == CODE_SETUP) begin
                cmd_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign seq_err = cmd_q.seq_err;

endmodule

// File: rtl/lock_state_array.sv
module lock_state_array
    import flash_lock_pkg::*;
#(
    parameter int BLOCKS = 12,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lock_act_e        act,
    input  logic [IDX_W-1:0] act_blk,
    input  logic [IDX_W-1:0] rd_a_blk,
    output blk_state_e       rd_a_state,
    input  logic [IDX_W-1:0] rd_b_blk,
    output blk_state_e       rd_b_state
);

    blk_state_e st_q [BLOCKS];

    for (genvar g = 0; g < BLOCKS; g++) begin : g_blk
        blk_state_e st_d;

        always_comb begin
            st_d = st_q[g];
            if (act_blk == IDX_W'(g)) begin
                case (act)
                    ACT_LOCK:   if (st_q[g] != BLK_PINNED) st_d = BLK_LOCKED;
                    ACT_UNLOCK: if (st_q[g] != BLK_PINNED) st_d = BLK_OPEN;
                    ACT_PIN:    st_d = BLK_PINNED;
                    default:    st_d = st_q[g];
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[g] <= BLK_LOCKED;
            else        st_q[g] <= st_d;
        end
    end

    always_comb begin
        rd_a_state = BLK_LOCKED;
        rd_b_state = BLK_LOCKED;
        for (int i = 0; i < BLOCKS; i++) begin
            if (rd_a_blk == IDX_W'(i)) rd_a_state = st_q[i];
            if (rd_b_blk == IDX_W'(i)) rd_b_state = st_q[i];
        end
    end

endmodule

// File: rtl/lock_op_gate.sv
module lock_op_gate
    import flash_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_req,
    input  blk_state_e op_state,
    output logic       grant,
    output logic       deny
);

    gate_reg_t gate_d, gate_q;

    always_comb begin
        gate_d       = '0;
        gate_d.grant = op_req && (op_state == BLK_OPEN);
        gate_d.deny  = op_req && (op_state != BLK_OPEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign grant = gate_q.grant;
    assign deny  = gate_q.deny;

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
    import flash_lock_pkg::*;
#(
    parameter int  BLOCKS = 12,
    localparam int IDX_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_code,
    input  logic [IDX_W-1:0] cmd_blk,
    input  logic             op_req,
    input  logic [IDX_W-1:0] op_blk,
    input  logic [IDX_W-1:0] query_blk,
    output logic [1:0]       query_state,
    output logic             op_grant,
    output logic             sr_lock_err,
    output logic             sr_seq_err
);

    lock_act_e  act;
    blk_state_e q_state;
    blk_state_e o_state;

    lock_cmd_fsm u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_code (cmd_code),
        .act      (act),
        .seq_err  (sr_seq_err)
    );

    lock_state_array #(
        .BLOCKS (BLOCKS),
        .IDX_W  (IDX_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .act_blk    (cmd_blk),
        .rd_a_blk   (query_blk),
        .rd_a_state (q_state),
        .rd_b_blk   (op_blk),
        .rd_b_state (o_state)
    );

    lock_op_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_req   (op_req),
        .op_state (o_state),
        .grant    (op_grant),
        .deny     (sr_lock_err)
    );

    assign query_state = q_state;

endmodule

// File: rtl/flash_lock_ctrl_chk.sv
module flash_lock_ctrl_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic             op_req,
    input logic [IDX_W-1:0] query_blk,
    input logic [1:0]       query_state,
    input logic             op_grant,
    input logic             sr_lock_err,
    input logic             sr_seq_err
);

    assert_reset_locked_R1: assert property (@(posedge clk)
        !rst_n |=> (query_state == 2'b01 && !op_grant && !sr_lock_err && !sr_seq_err));

    assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        query_state != 2'b10);

    assert_pin_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(query_blk) && $past(query_state) == 2'b11) |-> query_state == 2'b11);

    assert_seq_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_seq_err |-> $past(cmd_wr));

    assert_op_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_grant || sr_lock_err) |-> $past(op_req));

    assert_op_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_grant && sr_lock_err));

endmodule

bind flash_lock_ctrl flash_lock_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .op_req      (op_req),
    .query_blk   (query_blk),
    .query_state (query_state),
    .op_grant    (op_grant),
    .sr_lock_err (sr_lock_err),
    .sr_seq_err  (sr_seq_err)
);

// File: tb/flash_lock_ctrl_bench.sv
module flash_lock_ctrl_bench;

    localparam int BLOCKS = 12;
    localparam int IDX_W  = 4;
    localparam int NVEC   = 13;

    // {first byte, second byte, block, expected state, expected error}
    localparam logic [22:0] VEC [NVEC] = '{
        {8'h60, 8'hD0, 4'd2,  2'b00, 1'b0},  // R4 open
        {8'h60, 8'h01, 4'd2,  2'b01, 1'b0},  // R3 lock
        {8'h60, 8'hD0, 4'd3,  2'b00, 1'b0},  // R4
        {8'h60, 8'h2F, 4'd3,  2'b11, 1'b0},  // R5 pin
        {8'h60, 8'hD0, 4'd3,  2'b11, 1'b0},  // R4 unlock on pinned
        {8'h60, 8'h01, 4'd3,  2'b11, 1'b0},  // R3 lock on pinned
        {8'h60, 8'hFF, 4'd4,  2'b01, 1'b1},  // R6 bad byte
        {8'h60, 8'h03, 4'd4,  2'b01, 1'b0},  // R7 config byte
        {8'h60, 8'h60, 4'd5,  2'b01, 1'b1},  // R6 repeated setup
        {8'h60, 8'hD0, 4'd11, 2'b00, 1'b0},  // R4 last block
        {8'h60, 8'hD0, 4'd12, 2'b01, 1'b0},  // R10 out of range
        {8'h60, 8'h2F, 4'd0,  2'b11, 1'b0},  // R5 first block
        {8'h20, 8'hD0, 4'd6,  2'b01, 1'b0}   // R8 no setup armed
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [7:0]       cmd_code = '0;
    logic [IDX_W-1:0] cmd_blk = '0;
    logic             op_req = 1'b0;
    logic [IDX_W-1:0] op_blk = '0;
    logic [IDX_W-1:0] query_blk = '0;
    logic [1:0]       query_state;
    logic             op_grant;
    logic             sr_lock_err;
    logic             sr_seq_err;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    flash_lock_ctrl #(.BLOCKS(BLOCKS)) u_flash_lock_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_code    (cmd_code),
        .cmd_blk     (cmd_blk),
        .op_req      (op_req),
        .op_blk      (op_blk),
        .query_blk   (query_blk),
        .query_state (query_state),
        .op_grant    (op_grant),
        .sr_lock_err (sr_lock_err),
        .sr_seq_err  (sr_seq_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] code, input logic [IDX_W-1:0] blk);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_code = code;
        cmd_blk  = blk;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic op(input logic [IDX_W-1:0] blk);
        @(negedge clk);
        op_req = 1'b1;
        op_blk = blk;
        @(negedge clk);
        op_req = 1'b0;
    endtask

    task automatic look(input string req, input logic [IDX_W-1:0] blk, input logic [1:0] exp);
        query_blk = blk;
        #1;
        check(req, int'(query_state), int'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        look("R1 reset state blk0", 4'd0, 2'b01);
        look("R1 reset state blk11", 4'd11, 2'b01);
        check("R1 grant low", int'(op_grant), 0);
        check("R1 seq err low", int'(sr_seq_err), 0);
        look("R2 out-of-range query", 4'd14, 2'b01);

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][22:15], VEC[i][6:3]);
            wr(VEC[i][14:7],  VEC[i][6:3]);
            check($sformatf("R6 err flag vector %0d", i), int'(sr_seq_err), int'(VEC[i][0]));
            look($sformatf("R3 R4 R5 state vector %0d", i), VEC[i][6:3], VEC[i][2:1]);
            @(negedge clk);
            check($sformatf("R6 err one cycle vector %0d", i), int'(sr_seq_err), 0);
        end

        // R6: setup is dropped after a bad byte
        wr(8'h60, 4'd4);
        wr(8'h55, 4'd4);
        check("R6 err on 0x55", int'(sr_seq_err), 1);
        wr(8'hD0, 4'd4);
        check("R8 no err after dropped setup", int'(sr_seq_err), 0);
        look("R8 blk4 unchanged", 4'd4, 2'b01);

        // R2: live query follows index in the same cycle
        look("R2 query blk11", 4'd11, 2'b00);
        look("R2 query blk3", 4'd3, 2'b11);

        // R9 requests
        op(4'd2);
        check("R9 locked grant", int'(op_grant), 0);
        check("R9 locked refuse", int'(sr_lock_err), 1);
        op(4'd11);
        check("R9 open grant", int'(op_grant), 1);
        check("R9 open refuse", int'(sr_lock_err), 0);
        op(4'd3);
        check("R9 pinned refuse", int'(sr_lock_err), 1);
        op(4'd12);
        check("R9 out-of-range refuse", int'(sr_lock_err), 1);
        check("R9 out-of-range grant", int'(op_grant), 0);
        @(negedge clk);
        check("R9 pulse one cycle", int'(sr_lock_err), 0);
        look("R9 pinned unchanged", 4'd3, 2'b11);
        look("R9 open unchanged", 4'd11, 2'b00);

        // R1: reset clears pinned and open blocks to locked
        do_reset();
        look("R1 pinned back to locked", 4'd3, 2'b01);
        look("R1 blk0 back to locked", 4'd0, 2'b01);
        look("R1 open back to locked", 4'd11, 2'b01);
        wr(8'hD0, 4'd3);
        look("R1 no setup armed after reset", 4'd3, 2'b01);
        wr(8'h60, 4'd3);
        wr(8'hD0, 4'd3);
        look("R4 unlock after reset", 4'd3, 2'b00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule